// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a requester and a byte-wide parallel flash device on a simple write-capable expansion bus. The requester asks for one of three operations: program one byte, erase one sector, or erase the whole chip. The block then issues the unlock and command write cycles that the flash expects, using fixed magic addresses and data bytes. It drives the address, the write data, an active-low chip select, an active-low output enable and an active-low write strobe.

After the last write, the block can optionally poll. It reads the target location and watches data bit 7 until the flash reports that the operation is finished. It stops early with a timeout flag if the poll budget runs out. It then pulses done for one clock. Only one request is in flight at a time. A start that arrives while the block is busy is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: With opcode 0 (program), the block issues exactly four write strobes, in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the request address with the request data byte.
- R2: With opcode 2 (chip erase), the block issues exactly six write strobes, in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10.
- R3: With opcode 1 (sector erase), the first five writes are the same as for chip erase. The sixth write goes to the request address with data 0x30.
- R4: Each write strobe stays low for exactly WE_LOW clocks. Between two strobes the write strobe is high for at least one clock. Chip select is low whenever the write strobe or the output enable is low, and the write strobe and the output enable are never low together.
- R5: The address and the write data stay constant for the whole time the write strobe is low, so the address seen at the falling edge equals the address seen at the rising edge.
- R6: When a program request is made with polling, every poll read addresses the request address. Completion is taken when the read bit 7 equals bit 7 of the programmed data.
- R7: When an erase request (sector or chip) is made with polling, every poll read addresses the request address. Completion is taken when the read bit 7 is 1.
- R8: If POLL_LIMIT reads pass without completion, the block stops polling and reports done with timeout high. Otherwise timeout is low when done is reported.
- R9: When a request is made with polling disabled, no read cycle takes place. Done follows the last write, with timeout low.
- R10: Busy goes high in the clock after a start is accepted and stays high until done. Busy is low while done is high. A start that arrives while busy is ignored, and the sequence in progress is not disturbed.
- R11: A start with opcode 3 is ignored: no bus cycle, no busy and no done.
- R12: While reset is applied, and after it, chip select, output enable and write strobe are high, and busy and done are low.
- R13: Done is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | Request pulse, sampled while idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 ignored |
| req_addr | input | ADDR_W | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| req_poll | input | 1 | Poll bit 7 after the command when high |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Valid with done: the poll budget ran out |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rd_msb | input | 1 | Flash read data bit 7 |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |

## Verification
The step counter or the opcode register could land in a wrong state. That shows up as a wrong address or data byte, or a wrong write count, at the very next rising edge of the write strobe. It is visible within one bus cycle and is checked against the expected order computed for each opcode. The poll counter could also go wrong. That shows up only at done, as a wrong number of output-enable pulses or a wrong timeout flag, so the busy-read count is swept from zero to past the limit. A strobe-timing fault is visible in the very clock where it happens, as a wrong low width or as a strobe without chip select.

// File: rtl/flash_seq_pkg.sv
// Shared types and constants for the flash command sequencer.
// Assumes 16 or more address bits, so that the unlock addresses fit.
package flash_seq_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } fop_e;

    localparam logic [15:0] UNLOCK_HI = 16'h5555;
    localparam logic [15:0] UNLOCK_LO = 16'h2AAA;
    localparam logic [7:0]  KEY_A     = 8'hAA;
    localparam logic [7:0]  KEY_B     = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam int          STEP_W    = 3;
endpackage

// File: rtl/flash_cmd_table.sv
// Gives the address and data of each write step for a given opcode.
// Assumes that step counts up from 0. Program has 4 steps and both erases
// have 6. The last flag is raised on the final step.
module flash_cmd_table
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  fop_e                      op,
    input  logic [STEP_W-1:0]         step,
    input  logic [ADDR_W-1:0]         tgt_addr,
    input  logic [7:0]                tgt_data,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [7:0]                wr_data,
    output logic                      last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_LO);

    // Pick the address and data for the current step.
    always_comb begin
        wr_addr = A_HI;
        wr_data = KEY_A;
        last    = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0: begin wr_addr = A_HI; wr_data = KEY_A; end
                3'd1: begin wr_addr = A_LO; wr_data = KEY_B; end
                3'd2: begin wr_addr = A_HI; wr_data = CMD_PROG; end
                default: begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                    last    = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin wr_addr = A_HI; wr_data = KEY_A; end
                3'd1: begin wr_addr = A_LO; wr_data = KEY_B; end
                3'd2: begin wr_addr = A_HI; wr_data = CMD_ERASE; end
                3'd3: begin wr_addr = A_HI; wr_data = KEY_A; end
                3'd4: begin wr_addr = A_LO; wr_data = KEY_B; end
                default: begin
                    if (op == OP_SECT) begin
                        wr_addr = tgt_addr;
                        wr_data = CMD_SECT;
                    end else begin
                        wr_addr = A_HI;
                        wr_data = CMD_CHIP;
                    end
                    last = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_bus_cycle.sv
// Runs one bus cycle on the flash pins: a write or a read.
// Write: 1 setup clock, then WE_LOW clocks with the strobe low, then 1 hold
// clock. Read: RD_CLKS clocks with the output enable low (bit 7 is captured
// on the last one), then 1 recovery clock. Assumes go comes only while idle.
module flash_bus_cycle #(
    parameter int ADDR_W  = 20,
    parameter int WE_LOW  = 2,
    parameter int RD_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic              rd_msb_in,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_cs_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              cyc_done,
    output logic              rd_msb
);
    localparam int MAXW = (WE_LOW > RD_CLKS) ? WE_LOW : RD_CLKS;
    localparam int CW   = $clog2(MAXW + 1);

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD, PH_READ, PH_REC
    } phase_e;

    phase_e        phase;
    logic [CW-1:0] cnt;

    // Step through the phases of the bus cycle and drive the registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            fl_addr  <= '0;
            fl_wdata <= '0;
            fl_cs_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            cyc_done <= 1'b0;
            rd_msb   <= 1'b0;
        end else begin
            cyc_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        fl_addr  <= addr_in;
                        fl_wdata <= data_in;
                        fl_cs_n  <= 1'b0;
                        cnt      <= '0;
                        if (rd) begin
                            fl_oe_n <= 1'b0;
                            phase   <= PH_READ;
                        end else begin
                            phase   <= PH_SETUP;
                        end
                    end
                end
                PH_SETUP: begin
                    fl_we_n <= 1'b0;
                    cnt     <= '0;
                    phase   <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt == CW'(WE_LOW - 1)) begin
                        fl_we_n <= 1'b1;
                        phase   <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    fl_cs_n  <= 1'b1;
                    cyc_done <= 1'b1;
                    phase    <= PH_IDLE;
                end
                PH_READ: begin
                    if (cnt == CW'(RD_CLKS - 1)) begin
                        rd_msb  <= rd_msb_in;
                        fl_oe_n <= 1'b1;
                        phase   <= PH_REC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_REC: begin
                    fl_cs_n  <= 1'b1;
                    cyc_done <= 1'b1;
                    phase    <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
// Counts poll reads and judges each sampled bit 7 against the expected value.
// Assumes that clear is held while idle and that sample pulses once per read.
module flash_poll_ctrl #(
    parameter int POLL_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit7,
    input  logic expect_bit,
    output logic hit,
    output logic last_try
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    logic [PW-1:0] tries;

    // Count the reads that have finished since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tries <= '0;
        end else if (sample) begin
            tries <= tries + 1'b1;
        end
    end

    // The read that is ending now is the last one the budget allows.
    assign last_try = (tries == PW'(POLL_LIMIT - 1));
    // Bit 7 has reached its final value.
    assign hit      = (bit7 == expect_bit);
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer. Accepts one request at a time, steps
// through its write sequence, optionally polls bit 7 at the request address,
// and then pulses done. Assumes that req_start is a pulse and that opcode 3
// is unused.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int WE_LOW     = 2,
    parameter int RD_CLKS    = 2,
    parameter int POLL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              req_poll,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic              fl_rd_msb,
    output logic              fl_cs_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

    state_e              st;
    fop_e                op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          data_q;
    logic                poll_q;
    logic                reading;
    logic                to_q;
    logic [STEP_W-1:0]   step;

    logic [ADDR_W-1:0]   tbl_addr;
    logic [7:0]          tbl_data;
    logic                tbl_last;
    logic                cyc_done;
    logic                rd_bit7;
    logic                hit;
    logic                last_try;

    flash_cmd_table #(.ADDR_W(ADDR_W)) u_table (
        .op       (op_q),
        .step     (step),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .last     (tbl_last)
    );

    flash_bus_cycle #(
        .ADDR_W  (ADDR_W),
        .WE_LOW  (WE_LOW),
        .RD_CLKS (RD_CLKS)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (st == S_ISSUE),
        .rd        (reading),
        .addr_in   (reading ? addr_q : tbl_addr),
        .data_in   (tbl_data),
        .rd_msb_in (fl_rd_msb),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_cs_n   (fl_cs_n),
        .fl_oe_n   (fl_oe_n),
        .fl_we_n   (fl_we_n),
        .cyc_done  (cyc_done),
        .rd_msb    (rd_bit7)
    );

    flash_poll_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (st == S_IDLE),
        .sample     (cyc_done && reading),
        .bit7       (rd_bit7),
        .expect_bit ((op_q == OP_PROG) ? data_q[7] : 1'b1),
        .hit        (hit),
        .last_try   (last_try)
    );

    // Sequence the request: accept it, issue the writes, poll, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            poll_q  <= 1'b0;
            reading <= 1'b0;
            to_q    <= 1'b0;
            step    <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_start && fop_e'(req_op) != OP_NONE) begin
                        op_q    <= fop_e'(req_op);
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        poll_q  <= req_poll;
                        reading <= 1'b0;
                        to_q    <= 1'b0;
                        step    <= '0;
                        st      <= S_ISSUE;
                    end
                end
                S_ISSUE: st <= S_WAIT;
                S_WAIT: begin
                    if (cyc_done) begin
                        if (reading) begin
                            if (hit) begin
                                st <= S_DONE;
                            end else if (last_try) begin
                                to_q <= 1'b1;
                                st   <= S_DONE;
                            end else begin
                                st <= S_ISSUE;
                            end
                        end else if (tbl_last) begin
                            if (poll_q) begin
                                reading <= 1'b1;
                                st      <= S_ISSUE;
                            end else begin
                                st <= S_DONE;
                            end
                        end else begin
                            step <= step + 1'b1;
                            st   <= S_ISSUE;
                        end
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Derive the status outputs from the sequencer state.
    assign busy    = (st == S_ISSUE) || (st == S_WAIT);
    assign done    = (st == S_DONE);
    assign timeout = (st == S_DONE) && to_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Checker for the flash command sequencer. It watches only the top-level
// pins and is attached to every instance of the top by the bind below.
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int WE_LOW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_cs_n,
    input logic              fl_oe_n,
    input logic              fl_we_n,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic              busy,
    input logic              done,
    input logic              timeout
);
    int low_run;

    // Count consecutive clocks with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n || fl_we_n) low_run <= 0;
        else                   low_run <= low_run + 1;
    end

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_run == WE_LOW));
    assert_cs_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_cs_n);
    assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    assert_addr_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));
    assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    assert_busy_clear_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .WE_LOW(WE_LOW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_cs_n  (fl_cs_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout)
);

// File: tb/sim_flash_cmd_seq.sv
// Bench for the flash command sequencer. It models the flash pins, logs every
// write at the rising strobe edge, answers poll reads with a scripted number of
// busy replies, and compares the results with sequences it computes itself.
module sim_flash_cmd_seq;
    localparam int AW  = 20;
    localparam int WL  = 3;
    localparam int RDC = 2;
    localparam int LIM = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_poll = 1'b0;
    logic          busy, done, timeout;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_rd_msb;
    logic          fl_cs_n, fl_oe_n, fl_we_n;

    flash_cmd_seq #(.ADDR_W(AW), .WE_LOW(WL), .RD_CLKS(RDC), .POLL_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_poll(req_poll),
        .busy(busy), .done(done), .timeout(timeout), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rd_msb(fl_rd_msb), .fl_cs_n(fl_cs_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    int            wr_n = 0;
    logic [AW-1:0] wr_a [8];
    logic [7:0]    wr_d [8];
    logic [AW-1:0] fall_a;
    int            rd_n = 0;
    int            busy_reads = 0;
    logic          busy_bit = 1'b0;
    logic          ready_bit = 1'b1;
    logic [AW-1:0] exp_rd_addr = '0;
    bit            bad_stab = 0, bad_width = 0, bad_cs = 0, bad_rdaddr = 0;
    int            run = 0;
    int            done_cnt = 0;
    bit            busy_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000", cycles);
            finish_run();
        end
    end

    // Flash model: the address is latched at the falling strobe edge, the data at the rising edge.
    always @(negedge fl_we_n) fall_a = fl_addr;
    always @(posedge fl_we_n) if (rst_n) begin
        if (fl_addr !== fall_a) bad_stab = 1;
        if (wr_n < 8) begin wr_a[wr_n] = fl_addr; wr_d[wr_n] = fl_wdata; end
        wr_n++;
    end
    always @(negedge fl_oe_n) if (fl_addr !== exp_rd_addr) bad_rdaddr = 1;
    always @(posedge fl_oe_n) if (rst_n) rd_n++;
    assign fl_rd_msb = (rd_n < busy_reads) ? busy_bit : ready_bit;

    // Pin timing monitor, sampled between clock edges.
    always @(negedge clk) if (rst_n) begin
        if ((!fl_we_n || !fl_oe_n) && fl_cs_n) bad_cs = 1;
        if (fl_we_n === 1'b0) run++;
        else begin
            if (run != 0 && run != WL) bad_width = 1;
            run = 0;
        end
        if (done) done_cnt++;
        if (busy) busy_seen = 1;
    end

    function automatic void exp_wr(input int op, input int i, input logic [AW-1:0] a,
                                   input logic [7:0] d, output logic [AW-1:0] ea,
                                   output logic [7:0] ed);
        logic [AW-1:0] hi = AW'(20'h05555);
        logic [AW-1:0] lo = AW'(20'h02AAA);
        if (op == 0) begin
            case (i)
                0: begin ea = hi; ed = 8'hAA; end
                1: begin ea = lo; ed = 8'h55; end
                2: begin ea = hi; ed = 8'hA0; end
                default: begin ea = a; ed = d; end
            endcase
        end else begin
            case (i)
                0, 3: begin ea = hi; ed = 8'hAA; end
                1, 4: begin ea = lo; ed = 8'h55; end
                2: begin ea = hi; ed = 8'h80; end
                default: begin
                    if (op == 1) begin ea = a; ed = 8'h30; end
                    else begin ea = hi; ed = 8'h10; end
                end
            endcase
        end
    endfunction

    task automatic clear_mon();
        wr_n = 0; rd_n = 0; done_cnt = 0; busy_seen = 0;
        bad_stab = 0; bad_width = 0; bad_cs = 0; bad_rdaddr = 0;
    endtask

    task automatic run_req(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                           input bit poll, input int nbusy, input bit intrude);
        int            nw = (op == 0) ? 4 : 6;
        string         rq = (op == 0) ? "R1" : (op == 1) ? "R3" : "R2";
        string         pr = (op == 0) ? "R6" : "R7";
        int            cyc = 0;
        int            exp_reads;
        bit            exp_to;
        bit            seq_ok;
        logic [AW-1:0] ea;
        logic [7:0]    ed;
        clear_mon();
        exp_rd_addr = a;
        busy_reads  = nbusy;
        busy_bit    = (op == 0) ? ~d[7] : 1'b0;
        ready_bit   = (op == 0) ?  d[7] : 1'b1;
        @(negedge clk);
        req_start = 1; req_op = 2'(op); req_addr = a; req_data = d; req_poll = poll;
        @(negedge clk);
        req_start = 0;
        chk(busy === 1'b1, "R10", "busy after start", busy, 1);
        while (done !== 1'b1 && cyc < 5000) begin
            if (intrude && cyc == 5) begin
                req_start = 1; req_op = 2'd2; req_addr = ~a; req_data = ~d; req_poll = 0;
            end else begin
                req_start = 0;
            end
            @(negedge clk);
            cyc++;
        end
        req_start = 0;
        chk(done === 1'b1, "R13", "done reached", done, 1);
        chk(busy === 1'b0, "R10", "busy low at done", busy, 0);
        exp_reads = !poll ? 0 : (nbusy + 1 <= LIM) ? nbusy + 1 : LIM;
        exp_to    = poll && (nbusy >= LIM);
        chk(timeout === exp_to, poll ? "R8" : "R9", "timeout", timeout, exp_to);
        chk(rd_n == exp_reads, poll ? pr : "R9", "poll read count", rd_n, exp_reads);
        chk(wr_n == nw, intrude ? "R10" : rq, "write count", wr_n, nw);
        seq_ok = 1;
        for (int i = 0; i < nw && i < 8; i++) begin
            exp_wr(op, i, a, d, ea, ed);
            if (wr_a[i] !== ea || wr_d[i] !== ed) begin
                seq_ok = 0;
                chk(0, rq, $sformatf("write %0d addr/data", i),
                    {wr_a[i], wr_d[i]}, {ea, ed});
            end
        end
        if (seq_ok) chk(1, rq, "write sequence", 0, 0);
        chk(!bad_rdaddr, pr, "poll read address", bad_rdaddr, 0);
        chk(!bad_stab, "R5", "address held across strobe", bad_stab, 0);
        chk(!bad_width && !bad_cs, "R4", "strobe width and chip select",
            {bad_width, bad_cs}, 0);
        @(negedge clk);
        chk(done === 1'b0 && done_cnt == 1, "R13", "done pulse count", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(fl_cs_n === 1 && fl_oe_n === 1 && fl_we_n === 1 && busy === 0 && done === 0,
            "R12", "reset pins", {fl_cs_n, fl_oe_n, fl_we_n, busy, done}, 5'b11100);
        rst_n = 1;
        @(negedge clk);
        chk(fl_cs_n === 1 && fl_we_n === 1 && busy === 0, "R12", "idle after reset",
            {fl_cs_n, fl_we_n, busy}, 3'b110);

        // Sweep the opcodes, data patterns and busy-read counts up to and past the limit.
        for (int op = 0; op < 3; op++)
            for (int di = 0; di < 6; di++)
                for (int nb = 0; nb <= LIM + 1; nb++)
                    run_req(op, AW'(op * 20'h1F3A7 + di * 20'h00B11 + nb * 7),
                            8'(di * 37 + 11) ^ (di[0] ? 8'h80 : 8'h00), 1'b1, nb, 1'b0);

        // Requests without polling.
        run_req(0, 20'hFFFFF, 8'hFF, 1'b0, 3, 1'b0);
        run_req(0, 20'h00000, 8'h00, 1'b0, 0, 1'b0);
        run_req(1, 20'h12345, 8'h00, 1'b0, 2, 1'b0);
        run_req(2, 20'h54321, 8'hFF, 1'b0, 2, 1'b0);

        // A start that arrives while busy must not disturb the running request.
        run_req(0, 20'h0ABCD, 8'h3C, 1'b1, 1, 1'b1);
        run_req(1, 20'h70000, 8'h00, 1'b1, 2, 1'b1);

        // Opcode 3 is ignored.
        clear_mon();
        @(negedge clk);
        req_start = 1; req_op = 2'd3; req_addr = 20'h11111; req_data = 8'h22; req_poll = 1;
        @(negedge clk);
        req_start = 0;
        repeat (30) @(negedge clk);
        chk(wr_n == 0 && rd_n == 0, "R11", "no bus cycle for opcode 3", wr_n + rd_n, 0);
        chk(!busy_seen && done_cnt == 0, "R11", "no busy or done for opcode 3",
            {busy_seen, done_cnt[0]}, 0);

        // A request after the ignored opcode still works.
        run_req(2, 20'h00042, 8'h00, 1'b1, 0, 1'b0);
        finish_run();
    end
endmodule